// File: doc/BRIEF.md
# UART FIFO Control and Line Status

This block sits between the host register interface of a 16550-class serial port and its two serial shifters. It holds a transmit queue and a receive queue. It decodes a write-only FIFO control register and produces the line status bits that depend on the queues. The host pushes transmit bytes and pops receive bytes. The transmit shifter pops from the transmit queue, and the receive shifter pushes received bytes. Each received byte carries three error tags, for parity, framing and break.

The control register selects between two modes. In FIFO mode each queue holds up to sixteen entries. In legacy mode each queue behaves as a single holding register. Switching between the modes empties both queues. A write to the control register can also empty either queue on its own and pick one of four receive thresholds. The block raises a receive-threshold request once the receive queue holds at least the selected number of bytes. The line status byte reports data ready, overrun, holding empty, transmitter empty and error-in-queue.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the block is in legacy mode with the 1-byte threshold selected. Both queues are empty, the status byte reads 0x60 while `tsr_busy` is low, and `rx_thr_irq` is low.
- R2: In FIFO mode each queue accepts 16 entries and returns them in push order with their error tags. In legacy mode each queue accepts one entry, and further pushes are dropped.
- R3: A control write with bit 0 at 0 selects legacy mode and empties both queues. A control write that changes the mode in either direction also empties both queues.
- R4: In a control write with bit 0 at 1, bit 1 set empties only the receive queue and bit 2 set empties only the transmit queue. Neither bit is held, so a later write without it leaves the queue contents alone.
- R5: Control bits 7:6 select the receive threshold: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. `rx_thr_irq` is high exactly when FIFO mode is on and the receive count is at or above the threshold.
- R6: Status bit 6 is 1 only when the transmit queue is empty and `tsr_busy` is low. Status bit 5 is 1 when the transmit queue is empty.
- R7: Status bit 7 is 0 in legacy mode. In FIFO mode it becomes 1 when a byte with a nonzero error tag (bit 0 parity, bit 1 framing, bit 2 break) enters the receive queue. It stays 1 until a status read (`lsr_rd`) finds no tagged byte left in the queue.
- R8: A push into a full receive queue is dropped and sets status bit 1. A status read clears that bit.
- R9: Status bit 0 is 1 whenever the receive queue holds at least one byte.
- R10: Control bits 5:3 have no effect: a write that differs from another only in those bits leaves the mode, the queues and the threshold the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| lsr_rd | input | 1 | Host read of the status byte; clears the sticky bits at the edge |
| lsr_q | output | 8 | Line status byte |
| fifo_mode | output | 1 | 1 in FIFO mode, 0 in legacy mode |
| tx_push | input | 1 | Host pushes a transmit byte |
| tx_wdata | input | 8 | Transmit byte to push |
| tx_full | output | 1 | Transmit queue at capacity for the current mode |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_rdata | output | 8 | Head of the transmit queue |
| tx_avail | output | 1 | Transmit queue not empty |
| tsr_busy | input | 1 | Transmit shift register holds a character |
| rx_push | input | 1 | Receive shifter pushes a byte |
| rx_wdata | input | 8 | Received byte |
| rx_werr | input | 3 | Error tag of the received byte: bit 0 parity, bit 1 framing, bit 2 break |
| rx_pop | input | 1 | Host takes the head byte |
| rx_rdata | output | 8 | Head of the receive queue |
| rx_rerr | output | 3 | Error tag of the head byte |
| rx_avail | output | 1 | Receive queue not empty |
| rx_thr_irq | output | 1 | Receive threshold request |

## Verification
The receive queue is filled with a stream whose bytes are all distinct and which has error tags at two separate positions. The stream is then drained against a bench-side queue, which catches reordering, lost tags and a wrong depth. The queue is filled one past capacity to separate a dropped push from a wrapped one. Each threshold code is run at one entry below its level and at its level, so an off-by-one comparison or a swapped table entry shows up. Control writes are tried with each reset bit alone, with the reserved bits set, and with mode changes in both directions, so that a reset bit that sticks, a clear that hits the wrong queue and a missing flush can each be told apart. The status read is issued once while a tagged byte is still queued and once after all tagged bytes have left, which separates a sticky error bit from one that merely tracks the queue.

// File: rtl/uart_fifo_pkg.sv
// Shared types and helpers for the UART FIFO control block.
// Assumes the receive threshold codes map to fixed byte counts.
package uart_fifo_pkg;

    // Receive threshold selection, as written in control bits 7:6
    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } rx_trig_e;

    // Error tag stored with every received byte (bit 0 parity)
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    localparam int ERR_W = 3;

    // Bit positions inside the line status byte
    localparam int ST_DREADY  = 0;
    localparam int ST_OVERRUN = 1;
    localparam int ST_THEMPTY = 5;
    localparam int ST_TEMPTY  = 6;
    localparam int ST_RXERR   = 7;

    // Maps a threshold code to the number of bytes it stands for
    function automatic int unsigned trig_bytes(input rx_trig_e code);
        case (code)
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/ufc_sync_fifo.sv
// Synchronous queue with a capacity that can be cut to one entry.
// Assumes DEPTH is a power of two. A clear has priority over push and
// pop in the same cycle. A push while full is dropped, even when a pop
// happens in the same cycle.
module ufc_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          one_deep,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          push_acc,
    output logic          pop_acc,
    output logic          push_drop
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;

    // Capacity limit and acceptance of push and pop
    always_comb begin
        cap       = one_deep ? CW'(1) : CW'(DEPTH);
        full      = (count >= cap);
        push_acc  = push && !full && !clr;
        pop_acc   = pop && (count != '0) && !clr;
        push_drop = push && full && !clr;
        dout      = mem[rd_ptr];
    end

    // Storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (push_acc) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) wr_ptr <= wr_ptr + 1'b1;
            if (pop_acc)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_acc, pop_acc})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ufc_ctrl_reg.sv
// Write-only FIFO control register decode.
// Bit 0 selects FIFO mode. Bits 1 and 2 are one-cycle clear pulses for
// the receive and transmit queues. Bits 7:6 pick the receive threshold.
// Bits 1, 2 and 7:6 take effect only when bit 0 is 1 in the same write.
module ufc_ctrl_reg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output rx_trig_e   trig,
    output logic       flush,
    output logic       rx_clr,
    output logic       tx_clr
);

    logic unused_cfg_bits;

    // Clear pulses: a write of bit 0 = 0 or any mode change empties both queues
    always_comb begin
        flush  = wr_en && (!wdata[0] || !fifo_en);
        rx_clr = flush || (wr_en && wdata[0] && wdata[1]);
        tx_clr = flush || (wr_en && wdata[0] && wdata[2]);
    end

    assign unused_cfg_bits = ^wdata[5:3];

    // Held fields of the register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            trig    <= TRIG_1;
        end else if (wr_en) begin
            fifo_en <= wdata[0];
            if (wdata[0]) trig <= rx_trig_e'(wdata[7:6]);
        end
    end

endmodule

// File: rtl/ufc_line_status.sv
// Line status bits and the receive threshold request.
// Keeps a count of error-tagged bytes in the receive queue and a sticky
// error flag, which a status read clears only once the count is zero.
// Overrun is sticky until a status read; a drop in the same cycle wins.
module ufc_line_status
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  rx_trig_e      trig,
    input  logic          flush,
    input  logic          rx_clr,
    input  logic          rx_in_err,
    input  logic          rx_out_err,
    input  logic          rx_drop,
    input  logic [CW-1:0] rx_count,
    input  logic          tx_empty,
    input  logic          tsr_busy,
    input  logic          lsr_rd,
    output logic [7:0]    lsr_q,
    output logic          thr_irq
);

    logic [CW-1:0] err_cnt, err_cnt_n;
    logic          err_flag, overrun;

    // Next count of error-tagged bytes still queued
    always_comb begin
        err_cnt_n = err_cnt;
        if (rx_clr) err_cnt_n = '0;
        else begin
            case ({rx_in_err, rx_out_err})
                2'b10:   err_cnt_n = err_cnt + 1'b1;
                2'b01:   err_cnt_n = err_cnt - 1'b1;
                default: err_cnt_n = err_cnt;
            endcase
        end
    end

    // Sticky error flag, overrun flag and tagged-byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt  <= '0;
            err_flag <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            err_cnt  <= err_cnt_n;
            err_flag <= !flush && ((err_cnt_n != '0) || (err_flag && !lsr_rd));
            overrun  <= rx_drop || (overrun && !lsr_rd);
        end
    end

    // Status byte assembly and threshold comparison
    always_comb begin
        lsr_q              = '0;
        lsr_q[ST_DREADY]   = (rx_count != '0);
        lsr_q[ST_OVERRUN]  = overrun;
        lsr_q[ST_THEMPTY]  = tx_empty;
        lsr_q[ST_TEMPTY]   = tx_empty && !tsr_busy;
        lsr_q[ST_RXERR]    = fifo_en && err_flag;
        thr_irq = fifo_en && ({{(32-CW){1'b0}}, rx_count} >= trig_bytes(trig));
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
// Top of the UART FIFO control block: control register, transmit and
// receive queues, and line status. Assumes the shifters and the host
// respect tx_avail/rx_avail before popping; a pop of an empty queue is ignored.
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic             lsr_rd,
    output logic [7:0]       lsr_q,
    output logic             fifo_mode,
    input  logic             tx_push,
    input  logic [7:0]       tx_wdata,
    output logic             tx_full,
    input  logic             tx_pop,
    output logic [7:0]       tx_rdata,
    output logic             tx_avail,
    input  logic             tsr_busy,
    input  logic             rx_push,
    input  logic [7:0]       rx_wdata,
    input  logic [ERR_W-1:0] rx_werr,
    input  logic             rx_pop,
    output logic [7:0]       rx_rdata,
    output logic [ERR_W-1:0] rx_rerr,
    output logic             rx_avail,
    output logic             rx_thr_irq
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int RX_W = 8 + ERR_W;

    rx_trig_e        trig;
    logic            flush, rx_clr, tx_clr;
    logic [CW-1:0]   tx_count, rx_count;
    logic            tx_push_acc, tx_pop_acc, tx_drop;
    logic            rx_full, rx_push_acc, rx_pop_acc, rx_drop;
    logic [RX_W-1:0] rx_head;

    ufc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wdata   (cfg_wdata),
        .fifo_en (fifo_mode),
        .trig    (trig),
        .flush   (flush),
        .rx_clr  (rx_clr),
        .tx_clr  (tx_clr)
    );

    ufc_sync_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tx_clr),
        .one_deep  (!fifo_mode),
        .push      (tx_push),
        .din       (tx_wdata),
        .pop       (tx_pop),
        .dout      (tx_rdata),
        .count     (tx_count),
        .full      (tx_full),
        .push_acc  (tx_push_acc),
        .pop_acc   (tx_pop_acc),
        .push_drop (tx_drop)
    );

    ufc_sync_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_clr),
        .one_deep  (!fifo_mode),
        .push      (rx_push),
        .din       ({rx_werr, rx_wdata}),
        .pop       (rx_pop),
        .dout      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .push_acc  (rx_push_acc),
        .pop_acc   (rx_pop_acc),
        .push_drop (rx_drop)
    );

    ufc_line_status #(.CW(CW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_mode),
        .trig       (trig),
        .flush      (flush),
        .rx_clr     (rx_clr),
        .rx_in_err  (rx_push_acc && (rx_werr != '0)),
        .rx_out_err (rx_pop_acc && (rx_head[RX_W-1 -: ERR_W] != '0)),
        .rx_drop    (rx_drop),
        .rx_count   (rx_count),
        .tx_empty   (tx_count == '0),
        .tsr_busy   (tsr_busy),
        .lsr_rd     (lsr_rd),
        .lsr_q      (lsr_q),
        .thr_irq    (rx_thr_irq)
    );

    logic unused_acc;

    // Head split and queue-level outputs
    always_comb begin
        rx_rdata   = rx_head[7:0];
        rx_rerr    = rx_head[RX_W-1 -: ERR_W];
        rx_avail   = (rx_count != '0);
        tx_avail   = (tx_count != '0);
        unused_acc = tx_push_acc ^ tx_pop_acc ^ tx_drop ^ rx_full;
    end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
// Property checker for uart_fifo_ctrl, attached with bind.
// Observes top-level ports only.
module uart_fifo_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic       lsr_rd,
    input logic [7:0] lsr_q,
    input logic       fifo_mode,
    input logic       tx_avail,
    input logic       tsr_busy,
    input logic       rx_push,
    input logic       rx_pop,
    input logic       rx_avail,
    input logic       rx_thr_irq
);

    a_r3_zero_write_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !cfg_wdata[0] |=> !fifo_mode && !rx_avail && !tx_avail);

    a_r4_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_wdata[0] && cfg_wdata[1] |=> !rx_avail);

    a_r2_legacy_single: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode && rx_avail && rx_push && !rx_pop && !cfg_wr |=> lsr_q[1]);

    a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !rx_push |=> !lsr_q[1]);

    a_r5_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_thr_irq |-> fifo_mode && rx_avail);

    a_r6_temt_empty: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_q[6] |-> !tsr_busy && !tx_avail);

    a_r7_err_legacy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !lsr_q[7]);

    a_r9_ready_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_q[0] == rx_avail);

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .lsr_rd     (lsr_rd),
    .lsr_q      (lsr_q),
    .fifo_mode  (fifo_mode),
    .tx_avail   (tx_avail),
    .tsr_busy   (tsr_busy),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .rx_avail   (rx_avail),
    .rx_thr_irq (rx_thr_irq)
);

// File: tb/uart_fifo_ctrl_tb.sv
// Directed bench for uart_fifo_ctrl: one task per scenario.
module uart_fifo_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       lsr_rd = 1'b0;
    logic [7:0] lsr_q;
    logic       fifo_mode;
    logic       tx_push = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       tx_full;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_rdata;
    logic       tx_avail;
    logic       tsr_busy = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_wdata = '0;
    logic [2:0] rx_werr = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_rdata;
    logic [2:0] rx_rerr;
    logic       rx_avail;
    logic       rx_thr_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .lsr_rd(lsr_rd), .lsr_q(lsr_q), .fifo_mode(fifo_mode),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_avail(tx_avail),
        .tsr_busy(tsr_busy), .rx_push(rx_push), .rx_wdata(rx_wdata),
        .rx_werr(rx_werr), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_rerr(rx_rerr), .rx_avail(rx_avail), .rx_thr_irq(rx_thr_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rxp(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk); rx_push = 1'b1; rx_wdata = d; rx_werr = e;
        @(negedge clk); rx_push = 1'b0; rx_werr = '0;
    endtask

    task automatic rxpop();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic txp(input logic [7:0] d);
        @(negedge clk); tx_push = 1'b1; tx_wdata = d;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic txpop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic lsrrd();
        @(negedge clk); lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "status", 32'(lsr_q), 32'h60);
        check("R1", "mode", 32'(fifo_mode), 0);
        check("R1", "irq", 32'(rx_thr_irq), 0);
        check("R1", "queues", 32'({rx_avail, tx_avail}), 0);
    endtask

    task automatic t_legacy();
        rxp(8'hA5, 3'b001);
        check("R7", "status legacy tagged", 32'(lsr_q), 32'h61);
        check("R5", "no irq in legacy", 32'(rx_thr_irq), 0);
        rxp(8'h3C, 3'b000);
        check("R8", "legacy overrun", 32'(lsr_q), 32'h63);
        check("R2", "legacy head kept", 32'(rx_rdata), 32'hA5);
        lsrrd();
        check("R8", "overrun cleared", 32'(lsr_q), 32'h61);
        rxpop();
        check("R9", "empty status", 32'(lsr_q), 32'h60);
        txp(8'h11);
        check("R2", "tx legacy full", 32'(tx_full), 1);
        check("R6", "status tx loaded", 32'(lsr_q), 32'h00);
        txp(8'h22);
        check("R2", "tx legacy head", 32'(tx_rdata), 32'h11);
        txpop();
        check("R2", "tx legacy single", 32'(tx_avail), 0);
    endtask

    task automatic t_enable();
        logic [10:0] q[$];
        rxp(8'h77, 3'b000);
        cfg(8'h01);
        check("R3", "mode on", 32'(fifo_mode), 1);
        check("R3", "flush on enable", 32'(rx_avail), 0);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d = 8'(i * 29 + 3);
            logic [2:0] e = (i == 5) ? 3'b010 : ((i == 9) ? 3'b100 : 3'b000);
            rxp(d, e);
            q.push_back({e, d});
            if (i == 0) check("R5", "irq at level 1", 32'(rx_thr_irq), 1);
        end
        check("R7", "err flag set", 32'(lsr_q[7]), 1);
        check("R8", "no overrun at 16", 32'(lsr_q[1]), 0);
        rxp(8'hEE, 3'b000);
        check("R8", "overrun at 17", 32'(lsr_q[1]), 1);
        for (int i = 0; i < 16; i++) begin
            logic [10:0] exp = q.pop_front();
            check("R2", "rx order", 32'({rx_rerr, rx_rdata}), 32'(exp));
            rxpop();
            if (i == 5) begin
                lsrrd();
                check("R7", "err kept while tagged queued", 32'(lsr_q[7]), 1);
            end
        end
        check("R7", "err sticky after drain", 32'(lsr_q[7]), 1);
        lsrrd();
        check("R7", "err cleared by read", 32'(lsr_q[7]), 0);
    endtask

    task automatic t_threshold();
        for (int t = 0; t < 4; t++) begin
            int lvl = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
            cfg({2'(t), 6'b000011});
            for (int k = 0; k < lvl - 1; k++) rxp(8'(k), 3'b000);
            check("R5", "below level", 32'(rx_thr_irq), 0);
            rxp(8'hF0, 3'b000);
            check("R5", "at level", 32'(rx_thr_irq), 1);
            cfg({2'(t), 6'b111001});
            check("R10", "reserved bits keep irq", 32'(rx_thr_irq), 1);
            check("R10", "reserved bits keep mode", 32'(fifo_mode), 1);
            rxpop();
            check("R5", "one below after pop", 32'(rx_thr_irq), 0);
        end
    endtask

    task automatic t_self_clear();
        cfg(8'h07);
        txp(8'h10); txp(8'h20);
        rxp(8'h01, 3'b000); rxp(8'h02, 3'b000); rxp(8'h03, 3'b000);
        cfg(8'h03);
        check("R4", "rx cleared", 32'(rx_avail), 0);
        check("R4", "tx untouched", 32'(tx_rdata), 32'h10);
        rxp(8'h44, 3'b000);
        cfg(8'h01);
        check("R4", "rx clear not held", 32'(rx_rdata), 32'h44);
        cfg(8'h05);
        check("R4", "tx cleared", 32'(tx_avail), 0);
        check("R4", "rx untouched", 32'(rx_avail), 1);
        rxpop();
    endtask

    task automatic t_temt();
        @(negedge clk); tsr_busy = 1'b1;
        @(negedge clk);
        check("R6", "busy shifter", 32'(lsr_q[6:5]), 32'b01);
        txp(8'h5A);
        check("R6", "both loaded", 32'(lsr_q[6:5]), 32'b00);
        @(negedge clk); tsr_busy = 1'b0;
        @(negedge clk);
        check("R6", "queue loaded", 32'(lsr_q[6:5]), 32'b00);
        check("R2", "tx head", 32'(tx_rdata), 32'h5A);
        txpop();
        check("R6", "all empty", 32'(lsr_q[6:5]), 32'b11);
        for (int i = 0; i < 16; i++) txp(8'(i));
        check("R2", "tx full at 16", 32'(tx_full), 1);
    endtask

    task automatic t_mode_switch();
        rxp(8'h99, 3'b100);
        check("R7", "tag seen", 32'(lsr_q[7]), 1);
        cfg(8'h00);
        check("R3", "legacy after zero write", 32'(fifo_mode), 0);
        check("R3", "queues emptied", 32'({rx_avail, tx_avail}), 0);
        check("R7", "err zero in legacy", 32'(lsr_q[7]), 0);
        txp(8'h33);
        cfg(8'h01);
        check("R3", "flush entering fifo mode", 32'(tx_avail), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legacy();
        t_enable();
        t_threshold();
        t_self_clear();
        t_temt();
        t_mode_switch();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule